// File: doc/BRIEF.md
# Signed-Digit Significand Rounder

This block takes a radix-10 significand held as signed digits and rounds it to the digits it keeps. It uses two extra digits below the last kept digit, a guard digit and a round digit. Each extra digit carries its own sign, so the discarded part can be positive or negative whatever the sign of the significand. A 3-bit mode selects one of six rounding rules. The result is a change of -1, 0 or +1 in the last kept digit. That change is applied as a signed-digit increment or decrement, which ripples only through digits already at the end of the digit range.

One registered stage sits between the inputs and the outputs. A floating-point datapath uses the block after an add or a multiply, before post-normalisation. The renormalise flag tells the next stage that the rounded fraction has reached magnitude one, or that its leading digit has become zero.

Each digit is a `DW`-bit two's-complement value in -9..+9. Digit 0, the least significant, sits at bits `[DW-1:0]`. The value of the significand is the sum of d_i·10^i, and its sign is the sign of the highest nonzero digit. The inputs must hold digits within -9..+9.

Top module: `sdr_round_unit`

## Requirements
- R1: Mode code 0 (truncate), and the unused codes 6 and 7, drop the guard and round digits and return the kept digits unchanged.
- R2: Mode code 1 (toward zero) subtracts 1 when the significand is positive and the extra value is negative. It adds 1 when the significand is negative and the extra value is positive. In every other case, including a zero significand, it truncates.
- R3: Mode code 2 (toward +∞) adds 1 when the extra value is positive and otherwise truncates, whatever the sign of the significand.
- R4: Mode code 3 (toward -∞) subtracts 1 when the extra value is negative and otherwise truncates, whatever the sign of the significand.
- R5: Mode code 4 (nearest-even) leaves the digits unchanged when |E| < 50. When |E| > 50 it moves one unit in the direction of the sign of E. At |E| = 50 it makes that move only when the last kept digit is odd.
- R6: Mode code 5 (nearest-odd) follows R5, except that at |E| = 50 it moves only when the last kept digit is even.
- R7: The extra value is E = 10·G + R, where G is the guard digit and R is the round digit, each signed. Its sign is the sign of E, and E is compared with the half point as |E| against 50. No sticky information takes part.
- R8: A +1 change turns each trailing +9 digit into 0 and adds 1 to the first digit above them. A -1 change turns each trailing -9 digit into 0 and subtracts 1 from the first digit above them. Every output digit stays within -9..+9.
- R9: `out_renorm` is 1 when the change ripples out of the top digit. It is also 1 when the top digit was nonzero before rounding and is zero after. Otherwise it is 0.
- R10: `out_valid` is `in_valid` delayed by one clock. The outputs take new values only in a cycle that follows an accepted input, and otherwise hold.
- R11: While `rst_n` is low, `out_valid`, `out_sig` and `out_renorm` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input strobe |
| in_sig | input | NDIG*DW | Kept significand digits, digit 0 lowest |
| in_guard | input | DW | Guard digit, signed |
| in_round | input | DW | Round digit, signed |
| in_mode | input | 3 | Rounding mode code |
| out_valid | output | 1 | Result strobe |
| out_sig | output | NDIG*DW | Rounded significand digits |
| out_renorm | output | 1 | Renormalisation needed |

## Verification
The bench builds the block with its defaults: six kept digits of five bits each. With six digits the whole significand value fits a bench integer, so the expected sign and digits are computed exactly. With six digits a ripple across every digit, or down to a zero leading digit, can also be set up directly. The random stimulus biases digits toward ±9 and extra digits toward the tie value, so that carry chains and ties under both nearest modes occur often.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  localparam int RADIX = 10;
  localparam int HALF  = RADIX * RADIX / 2;

  typedef enum logic [2:0] {
    MODE_CHOP      = 3'd0,
    MODE_ZERO      = 3'd1,
    MODE_UP        = 3'd2,
    MODE_DOWN      = 3'd3,
    MODE_NEAR_EVEN = 3'd4,
    MODE_NEAR_ODD  = 3'd5
  } rmode_e;

  typedef struct packed {
    logic up;
    logic dn;
  } adj_t;

  // Decision: one unit toward the side selected by mode and signs.
  function automatic adj_t pick_adjust(input logic [2:0] mode,
                                       input logic sig_pos, input logic sig_neg,
                                       input logic ext_pos, input logic ext_neg,
                                       input logic tie, input logic above,
                                       input logic last_odd);
    adj_t a;
    a = '0;
    case (mode)
      MODE_ZERO: begin
        a.dn = sig_pos & ext_neg;
        a.up = sig_neg & ext_pos;
      end
      MODE_UP:   a.up = ext_pos;
      MODE_DOWN: a.dn = ext_neg;
      MODE_NEAR_EVEN: if (above | (tie & last_odd)) begin
        a.up = ext_pos;
        a.dn = ext_neg;
      end
      MODE_NEAR_ODD: if (above | (tie & ~last_odd)) begin
        a.up = ext_pos;
        a.dn = ext_neg;
      end
      default: a = '0;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/sdr_extra_eval.sv
module sdr_extra_eval #(
  parameter int DW = 5
) (
  input  logic [DW-1:0] guard_d,
  input  logic [DW-1:0] round_d,
  output logic          ext_pos,
  output logic          ext_neg,
  output logic          ext_tie,
  output logic          ext_above
);
  int ext_val;
  int ext_mag;

  always_comb begin
    ext_val   = int'($signed(guard_d)) * sdr_pkg::RADIX + int'($signed(round_d));
    ext_mag   = (ext_val < 0) ? -ext_val : ext_val;
    ext_pos   = ext_val > 0;
    ext_neg   = ext_val < 0;
    ext_tie   = ext_mag == sdr_pkg::HALF;
    ext_above = ext_mag > sdr_pkg::HALF;
  end
endmodule

// File: rtl/sdr_sig_sign.sv
module sdr_sig_sign #(
  parameter int NDIG = 6,
  parameter int DW   = 5
) (
  input  logic [NDIG*DW-1:0] sig,
  output logic               sig_pos,
  output logic               sig_neg,
  output logic               msd_zero,
  output logic               last_odd
);
  always_comb begin
    sig_pos = 1'b0;
    sig_neg = 1'b0;
    for (int i = 0; i < NDIG; i++) begin
      if (sig[i*DW +: DW] != '0) begin
        sig_neg = sig[i*DW + DW - 1];
        sig_pos = ~sig[i*DW + DW - 1];
      end
    end
    msd_zero = sig[(NDIG-1)*DW +: DW] == '0;
    last_odd = sig[0];
  end
endmodule

// File: rtl/sdr_round_decide.sv
module sdr_round_decide (
  input  logic [2:0] mode,
  input  logic       sig_pos,
  input  logic       sig_neg,
  input  logic       ext_pos,
  input  logic       ext_neg,
  input  logic       ext_tie,
  input  logic       ext_above,
  input  logic       last_odd,
  output logic       adj_up,
  output logic       adj_dn
);
  sdr_pkg::adj_t adj;

  always_comb begin
    adj = sdr_pkg::pick_adjust(mode, sig_pos, sig_neg, ext_pos, ext_neg,
                               ext_tie, ext_above, last_odd);
    adj_up = adj.up;
    adj_dn = adj.dn;
  end
endmodule

// File: rtl/sdr_sd_incdec.sv
module sdr_sd_incdec #(
  parameter int NDIG = 6,
  parameter int DW   = 5
) (
  input  logic [NDIG*DW-1:0] sig,
  input  logic               adj_up,
  input  logic               adj_dn,
  output logic [NDIG*DW-1:0] res,
  output logic               carry_out
);
  localparam int DMAX = sdr_pkg::RADIX - 1;

  // two-bit signed transfer between neighbouring digits
  logic [2*(NDIG+1)-1:0] xfer;

  assign xfer[1:0] = adj_up ? 2'b01 : (adj_dn ? 2'b11 : 2'b00);

  for (genvar gi = 0; gi < NDIG; gi++) begin : g_digit
    logic [1:0]    x_out;
    logic [DW-1:0] d_out;
    int            s;

    always_comb begin
      s = int'($signed(sig[gi*DW +: DW])) + int'($signed(xfer[gi*2 +: 2]));
      if (s > DMAX) begin
        s     = s - sdr_pkg::RADIX;
        x_out = 2'b01;
      end else if (s < -DMAX) begin
        s     = s + sdr_pkg::RADIX;
        x_out = 2'b11;
      end else begin
        x_out = 2'b00;
      end
      d_out = DW'(s);
    end

    assign xfer[(gi+1)*2 +: 2] = x_out;
    assign res[gi*DW +: DW]    = d_out;
  end

  assign carry_out = xfer[2*NDIG +: 2] != 2'b00;
endmodule

// File: rtl/sdr_round_unit.sv
module sdr_round_unit #(
  parameter int NDIG = 6,
  parameter int DW   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [NDIG*DW-1:0] in_sig,
  input  logic [DW-1:0]      in_guard,
  input  logic [DW-1:0]      in_round,
  input  logic [2:0]         in_mode,
  output logic               out_valid,
  output logic [NDIG*DW-1:0] out_sig,
  output logic               out_renorm
);
  localparam int SIG_W = NDIG * DW;
  localparam int DMAX  = sdr_pkg::RADIX - 1;

  // named internal events
  logic ext_pos, ext_neg, ext_tie, ext_above;
  logic sig_pos, sig_neg, in_msd_zero, last_odd;
  logic adj_up, adj_dn, carry_out;
  logic [SIG_W-1:0] res_sig;
  logic res_msd_zero, renorm_d;

  sdr_extra_eval #(.DW(DW)) u_extra (
    .guard_d(in_guard), .round_d(in_round),
    .ext_pos(ext_pos), .ext_neg(ext_neg), .ext_tie(ext_tie), .ext_above(ext_above)
  );

  sdr_sig_sign #(.NDIG(NDIG), .DW(DW)) u_sign (
    .sig(in_sig), .sig_pos(sig_pos), .sig_neg(sig_neg),
    .msd_zero(in_msd_zero), .last_odd(last_odd)
  );

  sdr_round_decide u_decide (
    .mode(in_mode), .sig_pos(sig_pos), .sig_neg(sig_neg),
    .ext_pos(ext_pos), .ext_neg(ext_neg), .ext_tie(ext_tie), .ext_above(ext_above),
    .last_odd(last_odd), .adj_up(adj_up), .adj_dn(adj_dn)
  );

  sdr_sd_incdec #(.NDIG(NDIG), .DW(DW)) u_incdec (
    .sig(in_sig), .adj_up(adj_up), .adj_dn(adj_dn),
    .res(res_sig), .carry_out(carry_out)
  );

  assign res_msd_zero = res_sig[SIG_W-1 -: DW] == '0;
  assign renorm_d     = carry_out | (~in_msd_zero & res_msd_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sig    <= '0;
      out_renorm <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sig    <= res_sig;
        out_renorm <= renorm_d;
      end
    end
  end

  function automatic bit digits_ok(input logic [SIG_W-1:0] v);
    for (int i = 0; i < NDIG; i++) begin
      if (int'($signed(v[i*DW +: DW])) > DMAX || int'($signed(v[i*DW +: DW])) < -DMAX)
        return 1'b0;
    end
    return 1'b1;
  endfunction

  AST_CHOP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_mode == 3'd0 || in_mode > 3'd5)) |=> out_sig == $past(in_sig)); // R1
  AST_ZERO_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 3'd1 && sig_pos) |-> !adj_up); // R2
  AST_UP_NEVER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 3'd2) |-> !adj_dn); // R3
  AST_DOWN_NEVER_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 3'd3) |-> !adj_up); // R4
  AST_NEAR_BELOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_mode == 3'd4 || in_mode == 3'd5) && !ext_tie && !ext_above)
      |-> !adj_up && !adj_dn); // R5
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({adj_up, adj_dn})); // R7
  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> digits_ok(out_sig)); // R8
  AST_CARRY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && carry_out) |=> out_renorm); // R9
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_sig) && $stable(out_renorm)); // R10
endmodule

// File: tb/sdr_round_unit_bench.sv
module sdr_round_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NDIG = 6;
  localparam int DW   = 5;
  localparam int SW   = NDIG * DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [SW-1:0] in_sig = '0;
  logic [DW-1:0] in_guard = '0;
  logic [DW-1:0] in_round = '0;
  logic [2:0] in_mode = '0;
  logic out_valid;
  logic [SW-1:0] out_sig;
  logic out_renorm;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_round_unit #(.NDIG(NDIG), .DW(DW)) u_sdr_round_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sig(in_sig),
    .in_guard(in_guard), .in_round(in_round), .in_mode(in_mode),
    .out_valid(out_valid), .out_sig(out_sig), .out_renorm(out_renorm));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int dig(input logic [SW-1:0] v, input int i);
    return int'($signed(v[i*DW +: DW]));
  endfunction

  function automatic logic [SW-1:0] mk(input int d5, input int d4, input int d3,
                                       input int d2, input int d1, input int d0);
    logic [SW-1:0] v;
    v = {DW'(d5), DW'(d4), DW'(d3), DW'(d2), DW'(d1), DW'(d0)};
    return v;
  endfunction

  function automatic int sig_value(input logic [SW-1:0] v);
    int acc = 0;
    for (int i = NDIG - 1; i >= 0; i--) acc = acc * 10 + dig(v, i);
    return acc;
  endfunction

  // Expected unit change, from the rules R2..R7.
  function automatic int want_adj(input logic [2:0] m, input logic [SW-1:0] v,
                                  input int g, input int r);
    int e = 10 * g + r;
    int twice = (e < 0) ? -2 * e : 2 * e;
    int vv = sig_value(v);
    bit odd = (dig(v, 0) % 2) != 0;
    int dir = (e > 0) ? 1 : ((e < 0) ? -1 : 0);
    case (m)
      3'd1: return (vv > 0 && e < 0) ? -1 : ((vv < 0 && e > 0) ? 1 : 0);
      3'd2: return (e > 0) ? 1 : 0;
      3'd3: return (e < 0) ? -1 : 0;
      3'd4: return (twice > 100 || (twice == 100 && odd)) ? dir : 0;
      3'd5: return (twice > 100 || (twice == 100 && !odd)) ? dir : 0;
      default: return 0;
    endcase
  endfunction

  task automatic run_case(input string req, input logic [2:0] m, input logic [SW-1:0] v,
                          input int g, input int r);
    int a;
    int d [NDIG];
    int i;
    bit carry;
    logic [SW-1:0] ev;
    bit erenorm;
    a = want_adj(m, v, g, r);
    for (int k = 0; k < NDIG; k++) d[k] = dig(v, k);
    i = 0;
    while (a != 0 && i < NDIG) begin
      d[i] = d[i] + a;
      if (d[i] == 10 || d[i] == -10) begin
        d[i] = 0;
        i++;
      end else begin
        a = 0;
      end
    end
    carry = (a != 0);
    ev = '0;
    for (int k = 0; k < NDIG; k++) ev[k*DW +: DW] = DW'(d[k]);
    erenorm = carry || (dig(v, NDIG-1) != 0 && d[NDIG-1] == 0);
    in_valid = 1'b1;
    in_sig = v;
    in_mode = m;
    in_guard = DW'(g);
    in_round = DW'(r);
    @(negedge clk);
    chk(req, "out_sig", longint'(out_sig), longint'(ev));
    chk(req, "out_renorm", longint'(out_renorm), longint'(erenorm));
    chk("R10", "out_valid", longint'(out_valid), 1);
  endtask

  function automatic int rdig();
    int p = int'($urandom_range(0, 9));
    if (p < 2) return 9;
    if (p < 4) return -9;
    return int'($urandom_range(0, 18)) - 9;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R10 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] held;
    bit held_r;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "out_valid", longint'(out_valid), 0);
    chk("R11", "out_sig", longint'(out_sig), 0);
    chk("R11", "out_renorm", longint'(out_renorm), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 truncate and unused codes
    run_case("R1", 3'd0, mk(1,2,3,4,5,6), 9, 9);
    run_case("R1", 3'd6, mk(-1,2,-3,4,-5,6), 5, 0);
    run_case("R1", 3'd7, mk(-1,2,-3,4,-5,6), -9, -9);
    // R2 toward zero
    run_case("R2", 3'd1, mk(0,0,1,2,3,4), -1, 0);
    run_case("R2", 3'd1, mk(0,0,-1,2,3,4), 0, 3);
    run_case("R2", 3'd1, mk(0,0,0,0,0,0), -7, 0);
    run_case("R2", 3'd1, mk(0,0,1,2,3,4), 3, 0);
    // R3 / R4 directed, with full ripple
    run_case("R3", 3'd2, mk(9,9,9,9,9,9), 0, 1);
    run_case("R3", 3'd2, mk(-1,0,0,0,0,5), -4, 0);
    run_case("R4", 3'd3, mk(-9,-9,-9,-9,-9,-9), 0, -1);
    run_case("R4", 3'd3, mk(-2,0,0,0,0,5), -5, 0);
    // R5 / R6 ties
    run_case("R5", 3'd4, mk(0,0,0,0,1,3), 5, 0);
    run_case("R5", 3'd4, mk(0,0,0,0,1,4), 5, 0);
    run_case("R5", 3'd4, mk(0,0,0,0,1,3), -5, 0);
    run_case("R6", 3'd5, mk(0,0,0,0,1,4), 5, 0);
    run_case("R6", 3'd5, mk(0,0,0,0,1,4), -5, 0);
    run_case("R6", 3'd5, mk(0,0,0,0,1,3), 5, 0);
    // R7 extra value formed from both signed digits
    run_case("R7", 3'd4, mk(0,0,0,0,2,2), 5, -1);
    run_case("R7", 3'd4, mk(0,0,0,0,2,2), 6, -9);
    run_case("R7", 3'd5, mk(0,0,0,0,2,2), 4, 9);
    run_case("R7", 3'd2, mk(0,0,0,0,2,2), 1, -9);
    // R8 / R9 partial ripple, leading digit to zero
    run_case("R8", 3'd2, mk(3,-4,2,9,9,9), 0, 4);
    run_case("R9", 3'd3, mk(1,-9,-9,-9,-9,-9), -1, 0);

    // R10 hold while idle
    held = out_sig;
    held_r = out_renorm;
    in_valid = 1'b0;
    in_sig = mk(5,5,5,5,5,5);
    in_mode = 3'd2;
    in_guard = DW'(9);
    @(negedge clk);
    chk("R10", "idle out_valid", longint'(out_valid), 0);
    chk("R10", "idle out_sig", longint'(out_sig), longint'(held));
    chk("R10", "idle out_renorm", longint'(out_renorm), longint'(held_r));

    // random mix covering R1..R9
    for (int n = 0; n < 3000; n++) begin
      logic [SW-1:0] v;
      int g;
      int r;
      for (int k = 0; k < NDIG; k++) v[k*DW +: DW] = DW'(rdig());
      if ($urandom_range(0, 3) == 0) begin
        g = ($urandom_range(0, 1) == 0) ? 5 : -5;
        r = 0;
      end else begin
        g = int'($urandom_range(0, 18)) - 9;
        r = int'($urandom_range(0, 18)) - 9;
      end
      run_case("R8", 3'($urandom_range(0, 7)), v, g, r);
    end

    in_valid = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule